// File: doc/BRIEF.md
# Non-Restoring Array Divider

This block divides a signed dividend of 2N-1 bits by a signed divisor of N bits. It does so in one pass through an N-by-N grid of controlled adder/subtracter cells. Every cell holds one XOR gate and one full adder. Each row adds the divisor to the running partial remainder, or subtracts it, and the carry out of the row's most significant cell becomes one quotient bit. That bit then sets the operation of the row below. The top row always subtracts.

The grid itself is combinational. It sits between an operand register and a result register, so a request presented with `inValid` comes back two clock edges later with `outValid`. The remainder is the raw value left by the last row, with no correction step. When the final quotient bit is 0, that value is the true remainder minus the divisor. Overflow and a zero divisor are not detected.

Top module: `nrArrayDivider`

## Requirements
- R1: While `rstN` is low and after it is released with no request, `outValid` is 0 and `quotient` and `remainder` are 0.
- R2: `outValid` is 1 exactly on the cycle that follows the second rising edge after a cycle with `inValid` high, and 0 otherwise.
- R3: For a dividend with sign bit 0, a divisor with 0 < divisor < 2^(N-1), and the dividend's upper N bits (dividend >> (N-1)) less than the divisor, `quotient` equals floor(dividend / divisor), and its sign bit `quotient[N-1]` is 0.
- R4: Under the operand conditions of R3, `remainder` equals dividend mod divisor when `quotient[0]` is 1. When `quotient[0]` is 0, it equals (dividend mod divisor) minus divisor, modulo 2^N.
- R5: Operand values present while `inValid` is low are ignored. `quotient` and `remainder` hold their last values on every cycle in which `outValid` is 0.
- R6: Under the operand conditions of R3, quotient * divisor + fixedRem equals the dividend. Here fixedRem is `remainder` when `quotient[0]` is 1, and `remainder` + divisor otherwise.
- R7: A zero dividend with a valid divisor gives a zero quotient and a remainder of 2^N minus the divisor, because the first row subtracts unconditionally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Capture the operands on this edge |
| dividend | input | 2N-1 | Two's-complement dividend, MSB is sign |
| divisor | input | N | Two's-complement divisor, MSB is sign |
| outValid | output | 1 | Result registers hold a new result |
| quotient | output | N | Quotient, MSB is sign |
| remainder | output | N | Uncorrected final partial remainder |

## Verification
The hardest case to reach from the ports is a long chain of alternating add and subtract rows. In that chain the partial remainder goes negative, is restored by an adding row, and then the last row leaves a negative remainder. Whether that happens depends only on how the dividend's low bits line up with the divisor. For N=4 the stimulus therefore sweeps every dividend and divisor pair that meets the no-overflow condition. It then adds a seeded random stream of valid pairs and a zero-dividend case, which together cover both polarities of the final quotient bit.

// File: rtl/nrDivPkg.sv
package nrDivPkg;
  // strobes from the control to the datapath
  typedef struct packed {
    logic capIn;   // load operand registers
    logic capOut;  // load result registers
  } divStrobeT;
endpackage

// File: rtl/divCasCell.sv
module divCasCell (
  input  logic partIn,   // diagonal partial remainder bit
  input  logic carryIn,
  input  logic divBit,
  input  logic ctlBit,   // 1 = subtract, 0 = add
  output logic sumOut,
  output logic carryOut
);
  logic opBit;
  assign opBit    = divBit ^ ctlBit;
  assign sumOut   = partIn ^ carryIn ^ opBit;
  assign carryOut = (partIn & carryIn) | (opBit & carryIn) | (opBit & partIn);
endmodule

// File: rtl/divCasArray.sv
module divCasArray #(
  parameter int N = 8
) (
  input  logic [2*N-2:0] dividend,
  input  logic [N-1:0]   divisor,
  output logic [N-1:0]   quot,
  output logic [N-1:0]   rem
);
  logic [N-1:0][N-1:0] rowIn;
  logic [N-1:0][N-1:0] rowSum;
  logic [N-1:0][N:0]   rowCarry;
  logic [N:0]          ctlBit;

  // the top row always subtracts
  assign ctlBit[0] = 1'b1;

  for (genvar i = 0; i < N; i++) begin : gRow
    if (i == 0) begin : gTop
      assign rowIn[i] = dividend[2*N-2:N-1];
    end else begin : gNext
      assign rowIn[i] = {rowSum[i-1][N-2:0], dividend[N-1-i]};
    end
    // carry into the LSB cell equals the row's control bit (+1 on subtract)
    assign rowCarry[i][0] = ctlBit[i];
    for (genvar k = 0; k < N; k++) begin : gCol
      divCasCell uCell (
        .partIn  (rowIn[i][k]),
        .carryIn (rowCarry[i][k]),
        .divBit  (divisor[k]),
        .ctlBit  (ctlBit[i]),
        .sumOut  (rowSum[i][k]),
        .carryOut(rowCarry[i][k+1])
      );
    end
    assign ctlBit[i+1]  = rowCarry[i][N];
    assign quot[N-1-i]  = rowCarry[i][N];
  end

  assign rem = rowSum[N-1];
endmodule

// File: rtl/divDatapath.sv
module divDatapath
  import nrDivPkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  divStrobeT      strobe,
  input  logic [2*N-2:0] dividend,
  input  logic [N-1:0]   divisor,
  output logic [N-1:0]   quotient,
  output logic [N-1:0]   remainder
);
  localparam int DW = 2 * N - 1;

  logic [DW-1:0] opDividend;
  logic [N-1:0]  opDivisor;
  logic [N-1:0]  arrQuot;
  logic [N-1:0]  arrRem;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opDividend <= '0;
      opDivisor  <= '0;
    end else if (strobe.capIn) begin
      opDividend <= dividend;
      opDivisor  <= divisor;
    end
  end

  divCasArray #(.N(N)) uArray (
    .dividend(opDividend),
    .divisor (opDivisor),
    .quot    (arrQuot),
    .rem     (arrRem)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quotient  <= '0;
      remainder <= '0;
    end else if (strobe.capOut) begin
      quotient  <= arrQuot;
      remainder <= arrRem;
    end
  end
endmodule

// File: rtl/divCtrl.sv
module divCtrl
  import nrDivPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  output divStrobeT strobe,
  output logic      outValid
);
  logic stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1   <= 1'b0;
      outValid <= 1'b0;
    end else begin
      stage1   <= inValid;
      outValid <= stage1;
    end
  end

  assign strobe.capIn  = inValid;
  assign strobe.capOut = stage1;
endmodule

// File: rtl/nrArrayDivider.sv
module nrArrayDivider
  import nrDivPkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  input  logic [2*N-2:0] dividend,
  input  logic [N-1:0]   divisor,
  output logic           outValid,
  output logic [N-1:0]   quotient,
  output logic [N-1:0]   remainder
);
  divStrobeT strobe;

  divCtrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  divDatapath #(.N(N)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .dividend (dividend),
    .divisor  (divisor),
    .quotient (quotient),
    .remainder(remainder)
  );
endmodule

// File: rtl/nrArrayDividerChecker.sv
module nrArrayDividerChecker #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rstN,
  input logic           inValid,
  input logic [2*N-2:0] dividend,
  input logic [N-1:0]   divisor,
  input logic           outValid,
  input logic [N-1:0]   quotient,
  input logic [N-1:0]   remainder
);
  localparam int DW = 2 * N - 1;

  logic [1:0]    cyc;
  logic          vHist1, vHist2;
  logic [DW-1:0] hDend1, hDend2;
  logic [N-1:0]  hDsor1, hDsor2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cyc    <= '0;
      vHist1 <= 1'b0;
      vHist2 <= 1'b0;
      hDend1 <= '0;
      hDend2 <= '0;
      hDsor1 <= '0;
      hDsor2 <= '0;
    end else begin
      if (cyc != 2'd3) cyc <= cyc + 2'd1;
      vHist1 <= inValid;
      vHist2 <= vHist1;
      hDend1 <= dividend;
      hDend2 <= hDend1;
      hDsor1 <= divisor;
      hDsor2 <= hDsor1;
    end
  end

  logic          opsOk;
  logic [DW-1:0] qFull, rFull;
  logic [N-1:0]  fixedRem;
  logic [2*N-1:0] rebuilt;

  always_comb begin
    opsOk = !hDend2[DW-1] && !hDsor2[N-1] && (hDsor2 != '0)
            && ((hDend2 >> (N - 1)) < DW'(hDsor2));
    qFull = (hDsor2 != '0) ? hDend2 / DW'(hDsor2) : '0;
    rFull = (hDsor2 != '0) ? hDend2 % DW'(hDsor2) : '0;
    fixedRem = quotient[0] ? remainder : remainder + hDsor2;
    rebuilt = {{N{1'b0}}, quotient} * {{N{1'b0}}, hDsor2} + {{N{1'b0}}, fixedRem};
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= 2'd2) |-> (outValid == vHist2));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= 2'd1 && !outValid) |-> ($stable(quotient) && $stable(remainder)));

  assert_quotient_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= 2'd2 && outValid && opsOk) |-> (quotient == qFull[N-1:0] && !quotient[N-1]));

  assert_remainder_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= 2'd2 && outValid && opsOk) |->
      (remainder == (qFull[0] ? rFull[N-1:0] : rFull[N-1:0] - hDsor2)));

  assert_identity_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= 2'd2 && outValid && opsOk) |-> (rebuilt == {1'b0, hDend2}));
endmodule

bind nrArrayDivider nrArrayDividerChecker #(.N(N)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .dividend (dividend),
  .divisor  (divisor),
  .outValid (outValid),
  .quotient (quotient),
  .remainder(remainder)
);

// File: tb/nrArrayDivider_bench.sv
module nrArrayDivider_bench;
  localparam int N = 4;
  localparam int DW = 2 * N - 1;
  localparam int PERIOD = 10;
  localparam int MASK = (1 << N) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [DW-1:0] dividend = '0;
  logic [N-1:0]  divisor = '0;
  logic          outValid;
  logic [N-1:0]  quotient;
  logic [N-1:0]  remainder;

  int total = 0;
  int bad = 0;

  always #(PERIOD / 2) clk = ~clk;

  nrArrayDivider #(.N(N)) u_nrArrayDivider (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .dividend (dividend),
    .divisor  (divisor),
    .outValid (outValid),
    .quotient (quotient),
    .remainder(remainder)
  );

  function automatic int expQuot(int dd, int dv);
    return (dd / dv) & MASK;
  endfunction

  function automatic int expRem(int dd, int dv);
    int q = dd / dv;
    int r = dd % dv;
    return ((q & 1) != 0) ? r : ((r - dv) & MASK);
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at negedge, result sampled at the negedge after two rising edges
  task automatic runOp(int dd, int dv, bit zeroCase);
    int fixed;
    dividend = DW'(dd);
    divisor  = N'(dv);
    inValid  = 1'b1;
    @(negedge clk);
    inValid  = 1'b0;
    check("R2", int'(outValid), 0);
    @(negedge clk);
    check("R2", int'(outValid), 1);
    check("R3", int'(quotient), expQuot(dd, dv));
    check("R4", int'(remainder), expRem(dd, dv));
    fixed = quotient[0] ? int'(remainder) : ((int'(remainder) + dv) & MASK);
    check("R6", int'(quotient) * dv + fixed, dd);
    if (zeroCase) begin
      check("R7 quotient", int'(quotient), 0);
      check("R7 remainder", int'(remainder), (1 << N) - dv);
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int dd, dv;
    int oldQ, oldR;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 outValid", int'(outValid), 0);
    check("R1 quotient", int'(quotient), 0);
    check("R1 remainder", int'(remainder), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 outValid idle", int'(outValid), 0);
    check("R1 quotient idle", int'(quotient), 0);

    // R7 zero dividend
    runOp(0, 5, 1'b1);
    runOp(0, 1, 1'b1);

    // exhaustive sweep of non-overflowing pairs (R3, R4, R6)
    for (int v = 1; v < (1 << (N - 1)); v++) begin
      for (int d = 0; d < (1 << (DW - 1)); d++) begin
        if ((d >> (N - 1)) < v) runOp(d, v, 1'b0);
      end
    end

    // R5: operands changed without inValid are ignored
    runOp(45, 7, 1'b0);
    oldQ = int'(quotient);
    oldR = int'(remainder);
    dividend = DW'(13);
    divisor  = N'(2);
    repeat (3) @(negedge clk);
    check("R5 outValid", int'(outValid), 0);
    check("R5 quotient", int'(quotient), oldQ);
    check("R5 remainder", int'(remainder), oldR);

    // seeded random valid pairs
    for (int n = 0; n < 300; n++) begin
      dv = int'($urandom_range(1, (1 << (N - 1)) - 1));
      dd = int'($urandom_range(0, (dv << (N - 1)) - 1));
      runOp(dd, dv, 1'b0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule